// File: doc/BRIEF.md
# Interrupt Request Handshake Controller

This block sits between user logic and the interrupt port on the configuration side of a PCIe endpoint. It turns a level-style user interrupt into request/ready handshakes with the endpoint. The endpoint's core is out of scope and is modelled only by the testbench. Both handshake signals are active-high. The block raises `req_o` and holds it until it samples `rdy_i` high, then drops it on the very next cycle. Holding the request for one extra cycle would draw a second, unwanted ready pulse.

With `msi_en_i` low the block works in legacy line mode. A user interrupt produces an assert handshake. When the user later clears the condition, a deassert handshake follows, so each interrupt produces two messages. `assert_sel_o` tells the endpoint which of the two a request is.

With `msi_en_i` high, each interrupt produces a single message-write handshake, and no deassert handshake follows. A message-write may only start while bus mastering is enabled. If it is not, the interrupt waits and `pend_o` shows the wait. A protocol checker watches for a ready pulse that arrives with no request outstanding. It latches a sticky error when it sees one.

Top module: `irq_hs_ctrl`

## Requirements
- R1: After reset `req_o`, `assert_sel_o`, `msi_req_o`, `pend_o` and `err_o` are all 0.
- R2: Once `req_o` rises it stays high, and `assert_sel_o` and `msi_req_o` stay unchanged, until a cycle in which `rdy_i` is sampled high. `req_o` is 0 in the cycle right after that grant.
- R3: In legacy mode (`msi_en_i`=0), `irq_i`=1 while idle starts a request with `assert_sel_o`=1 and `msi_req_o`=0.
- R4: After the assert grant in legacy mode, no further request is made while `irq_i` stays 1. When `irq_i` goes to 0, a deassert request follows with `assert_sel_o`=0 and `msi_req_o`=0. After its grant the block is idle.
- R5: In MSI mode (`msi_en_i`=1, `bus_master_en_i`=1), `irq_i`=1 while idle starts exactly one request with `msi_req_o`=1 and `assert_sel_o`=0. No further request is made while `irq_i` stays 1, and none follows when `irq_i` falls.
- R6: A message-write request never starts while `bus_master_en_i`=0. During such a wait `pend_o`=1 and `req_o`=0. When `bus_master_en_i` becomes 1, the request is issued and `pend_o` returns to 0.
- R7: `rdy_i`=1 in a cycle where `req_o`=0 sets `err_o` on the next cycle. `err_o` stays 1 until reset.
- R8: A change of `msi_en_i` after a legacy assert takes effect only once the legacy deassert handshake completes. That deassert is still issued as a legacy request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | User interrupt condition, level |
| msi_en_i | input | 1 | 1 selects message-write mode, 0 selects legacy line mode |
| bus_master_en_i | input | 1 | Bus-master enable (command register bit 2) |
| rdy_i | input | 1 | Grant from the endpoint, active high |
| req_o | output | 1 | Interrupt request to the endpoint, active high |
| assert_sel_o | output | 1 | 1 = assert request, 0 = deassert (legacy) |
| msi_req_o | output | 1 | 1 while the outstanding request is a message-write |
| pend_o | output | 1 | Message-write waiting for bus-master enable |
| err_o | output | 1 | Sticky grant-without-request error |

## Verification
The assertions check several rules on every cycle: that a request is held with stable attributes until it is granted, that it drops in the cycle after the grant, that a message-write never starts without bus-master enable, that a pending wait never coexists with a request, and that the error flag sets and stays set. The pairing of legacy assert and deassert messages, the single message per interrupt in MSI mode, and the deferred effect of a mode change can only be shown by the bench's scenarios. The bench sweeps mode, bus-master enable and grant latency across these scenarios.

// File: rtl/irq_hs_pkg.sv
package irq_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_ASSERT,
    ST_ASSERTED,
    ST_REQ_DEASSERT,
    ST_REQ_MSI
  } irq_state_e;
endpackage

// File: rtl/irq_hs_fsm.sv
module irq_hs_fsm
  import irq_hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic msi_en_i,
  input  logic bus_master_en_i,
  input  logic rdy_i,
  output logic req_o,
  output logic assert_sel_o,
  output logic msi_req_o,
  output logic pend_o
);

  irq_state_e state_q, state_d;
  logic msi_served_q, msi_served_d;
  logic msi_want;

  // an MSI interrupt is consumed once; re-arm only after irq_i falls
  assign msi_want = irq_i & ~msi_served_q;

  always_comb begin
    state_d      = state_q;
    msi_served_d = msi_served_q & irq_i;
    unique case (state_q)
      ST_IDLE: begin
        if (!msi_en_i && irq_i)                        state_d = ST_REQ_ASSERT;
        else if (msi_en_i && msi_want && bus_master_en_i) state_d = ST_REQ_MSI;
      end
      ST_REQ_ASSERT:   if (rdy_i) state_d = ST_ASSERTED;
      ST_ASSERTED:     if (!irq_i) state_d = ST_REQ_DEASSERT;
      ST_REQ_DEASSERT: if (rdy_i) state_d = ST_IDLE;
      ST_REQ_MSI: begin
        if (rdy_i) begin
          state_d      = ST_IDLE;
          msi_served_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      msi_served_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      msi_served_q <= msi_served_d;
    end
  end

  assign req_o        = (state_q == ST_REQ_ASSERT) | (state_q == ST_REQ_DEASSERT) |
                        (state_q == ST_REQ_MSI);
  assign assert_sel_o = (state_q == ST_REQ_ASSERT);
  assign msi_req_o    = (state_q == ST_REQ_MSI);
  assign pend_o       = (state_q == ST_IDLE) & msi_en_i & msi_want & ~bus_master_en_i;

  a_r2_hold_until_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !rdy_i |=> req_o && $stable(assert_sel_o) && $stable(msi_req_o));

  a_r2_drop_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && rdy_i |=> !req_o);

  a_r6_msi_needs_bme: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && msi_req_o && !$past(req_o) |-> $past(bus_master_en_i));

  a_r6_pend_excludes_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> !req_o);

endmodule

// File: rtl/irq_hs_grant_chk.sv
module irq_hs_grant_chk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic rdy_i,
  output logic err_o
);

  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | (rdy_i & ~req_i);
  end

  assign err_o = err_q;

  a_r7_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_i && !req_i |=> err_o);

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

endmodule

// File: rtl/irq_hs_ctrl.sv
module irq_hs_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic msi_en_i,
  input  logic bus_master_en_i,
  input  logic rdy_i,
  output logic req_o,
  output logic assert_sel_o,
  output logic msi_req_o,
  output logic pend_o,
  output logic err_o
);

  logic req;

  irq_hs_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .irq_i           (irq_i),
    .msi_en_i        (msi_en_i),
    .bus_master_en_i (bus_master_en_i),
    .rdy_i           (rdy_i),
    .req_o           (req),
    .assert_sel_o    (assert_sel_o),
    .msi_req_o       (msi_req_o),
    .pend_o          (pend_o)
  );

  irq_hs_grant_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .rdy_i  (rdy_i),
    .err_o  (err_o)
  );

  assign req_o = req;

endmodule

// File: tb/irq_hs_ctrl_tb.sv
module irq_hs_ctrl_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic irq, msi_en, bme, rdy;
  logic req, sel, msi_req, pend, err;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  irq_hs_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .msi_en_i(msi_en),
    .bus_master_en_i(bme), .rdy_i(rdy), .req_o(req), .assert_sel_o(sel),
    .msi_req_o(msi_req), .pend_o(pend), .err_o(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
      finish_run();
    end
  end

  // wait for a request, check its kind, hold off the grant d cycles, then grant
  task automatic serve(input int d, input bit exp_sel, input bit exp_msi, input string tag);
    int w = 0;
    while (!req && w < 8) begin
      @(negedge clk);
      w++;
    end
    check(req == 1'b1, {tag, " request raised"}, int'(req), 1);
    check(sel == exp_sel, {tag, " assert_sel_o"}, int'(sel), int'(exp_sel));
    check(msi_req == exp_msi, {tag, " msi_req_o"}, int'(msi_req), int'(exp_msi));
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      check(req && sel == exp_sel && msi_req == exp_msi, "R2 held until grant",
            int'({req, sel, msi_req}), int'({1'b1, exp_sel, exp_msi}));
    end
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
    check(req == 1'b0, "R2 dropped cycle after grant", int'(req), 0);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req == 1'b0, tag, int'(req), 0);
    end
  endtask

  initial begin
    irq = 0; msi_en = 0; bme = 0; rdy = 0;
    repeat (3) @(negedge clk);
    check({req, sel, msi_req, pend, err} == 5'b0, "R1 reset outputs",
          int'({req, sel, msi_req, pend, err}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check({req, sel, msi_req, pend, err} == 5'b0, "R1 idle after reset",
          int'({req, sel, msi_req, pend, err}), 0);

    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 2; b++) begin
        for (int d = 0; d < 3; d++) begin
          msi_en = m[0]; bme = b[0];
          @(negedge clk);
          irq = 1'b1;
          if (m == 0) begin
            serve(d, 1'b1, 1'b0, "R3 legacy assert");
            quiet(3, "R4 no request while irq high");
            irq = 1'b0;
            serve(d, 1'b0, 1'b0, "R4 legacy deassert");
            quiet(2, "R4 idle after deassert");
          end else begin
            if (b == 0) begin
              for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(pend == 1'b1 && req == 1'b0, "R6 pending without bus master",
                      int'({pend, req}), 2);
              end
              bme = 1'b1;
            end
            serve(d, 1'b0, 1'b1, "R5 msi request");
            check(pend == 1'b0, "R6 pend cleared", int'(pend), 0);
            quiet(3, "R5 single msi while irq high");
            irq = 1'b0;
            quiet(3, "R5 no deassert in msi mode");
          end
          check(err == 1'b0, "R7 no error in clean handshakes", int'(err), 0);
        end
      end
    end

    // R8: mode flips while the legacy line is asserted
    msi_en = 1'b0; bme = 1'b1;
    @(negedge clk);
    irq = 1'b1;
    serve(1, 1'b1, 1'b0, "R8 legacy assert");
    msi_en = 1'b1;
    quiet(2, "R8 no msi while line asserted");
    irq = 1'b0;
    serve(1, 1'b0, 1'b0, "R8 deassert stays legacy");
    quiet(2, "R8 idle after deassert");

    // R7: stray grant
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
    check(err == 1'b1, "R7 stray grant flagged", int'(err), 1);
    repeat (4) @(negedge clk);
    check(err == 1'b1, "R7 error sticky", int'(err), 1);
    irq = 1'b1;
    serve(0, 1'b0, 1'b1, "R7 handshake after error");
    check(err == 1'b1, "R7 error still set", int'(err), 1);
    irq = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(err == 1'b0 && req == 1'b0, "R1 reset clears error",
          int'({err, req}), 0);

    finish_run();
  end
endmodule